// File: doc/BRIEF.md
# Signed Sequential Multiplier with Radix-2 Booth Recoding

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full `2*WIDTH`-bit product. A single working register holds three parts. The upper part is an accumulator one bit wider than an operand. The lower part starts out as the multiplier. One guard bit sits to the right of the lower part.

In every step the block looks at the lowest multiplier bit and the guard bit to its right. From that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. The whole register then shifts right by one place, and the accumulator keeps its sign as it shifts. A run of ones in the multiplier therefore costs one subtraction where the run begins and one addition just past its end.

A caller applies both operands and raises `start` for one cycle. Exactly `WIDTH + 1` cycles later the block raises `done` for one cycle, with the product already valid on `product`. The result stays on `product` until the next multiplication finishes.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is asserted, `product` reads 0 and `done` reads 0.
- R2: The step choice follows the pair {current multiplier bit, bit to its right}: 10 subtracts the multiplicand, 01 adds it, and 00 and 11 leave the accumulator unchanged. The implied bit right of bit 0 starts at 0. A multiplier of all ones therefore yields the negated multiplicand, and a multiplier of 1 yields the multiplicand.
- R3: The shift after each step is arithmetic on the accumulator, so negative partial results stay negative. A negative multiplicand or a negative multiplier gives the correctly signed product.
- R4: The accumulator is one bit wider than an operand, so the most negative multiplicand gives an exact product with any multiplier, including the most negative one.
- R5: When `start` is sampled high while the block is idle, `done` goes high exactly `WIDTH + 1` clock edges later, stays high for exactly one cycle, and `product` then equals the signed product of the operands sampled with `start`.
- R6: `start` and operand changes while a multiplication is in progress are ignored. The running result and its timing are unchanged.
- R7: `product` changes only at the edge where `done` rises, and it holds its value until the next multiplication completes.
- R8: For any pair of signed operands, `product` equals the low `2*WIDTH` bits of their signed product. Examples: 2 × 7 = 14 and 2 × −3 = −6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiplication when the block is idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled with start |
| multiplier | input | WIDTH | Signed multiplier, sampled with start |
| product | output | 2*WIDTH | Signed product, held until the next completion |
| done | output | 1 | One-cycle pulse when product becomes valid |

## Verification
Several multiplier patterns each drive one part of the recoding:
- All ones: a single subtract and no add.
- A value of 1: a subtract followed at once by an add.
- Alternating bits: an operation on every step.
- A block of ones in the middle: separated subtract and add.

Pairing these with positive, negative and most-negative multiplicands separates a wrong pair decode from a wrong sign-extending shift or a too-narrow accumulator. Random signed operand pairs cover the remaining space. The latency, the single-cycle `done` pulse and the hold of `product` are measured on every run. Some runs also pulse `start` mid-run with different operands to show that the busy block ignores it.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef struct packed {
    logic load;
    logic step;
    logic capture;
  } mulStrobe_t;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } boothOp_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } mulState_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mul_pkg::*;
(
  input  logic     curBit,
  input  logic     rightBit,
  output boothOp_t op
);

  always_comb begin
    unique case ({curBit, rightBit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_HOLD;
    endcase
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobe_t         strobe,
  input  logic [WIDTH-1:0]   mcandIn,
  input  logic [WIDTH-1:0]   mplierIn,
  output logic [2*WIDTH-1:0] resultOut
);

  localparam int AccW = WIDTH + 1;

  logic [AccW-1:0]    accHi;
  logic [AccW-1:0]    mcandExt;
  logic [WIDTH-1:0]   accLo;
  logic               guardBit;
  logic [AccW-1:0]    sumHi;
  logic [2*WIDTH-1:0] resultReg;
  boothOp_t           stepOp;

  booth_recoder recoder (
    .curBit  (accLo[0]),
    .rightBit(guardBit),
    .op      (stepOp)
  );

  always_comb begin
    unique case (stepOp)
      OP_ADD:  sumHi = accHi + mcandExt;
      OP_SUB:  sumHi = accHi - mcandExt;
      default: sumHi = accHi;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi    <= '0;
      accLo    <= '0;
      guardBit <= 1'b0;
      mcandExt <= '0;
    end else if (strobe.load) begin
      accHi    <= '0;
      accLo    <= mplierIn;
      guardBit <= 1'b0;
      mcandExt <= {mcandIn[WIDTH-1], mcandIn};
    end else if (strobe.step) begin
      accHi    <= {sumHi[AccW-1], sumHi[AccW-1:1]};
      accLo    <= {sumHi[0], accLo[WIDTH-1:1]};
      guardBit <= accLo[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
    end else if (strobe.capture) begin
      resultReg <= {accHi[WIDTH-1:0], accLo};
    end
  end

  assign resultOut = resultReg;

endmodule

// File: rtl/booth_control.sv
module booth_control
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       doneOut
);

  localparam int CntW = $clog2(WIDTH + 1);
  localparam logic [CntW-1:0] LastStep = CntW'(WIDTH - 1);

  mulState_t      state;
  logic [CntW-1:0] stepCnt;
  logic           doneReg;

  always_comb begin
    strobe.load    = (state == ST_IDLE) && start;
    strobe.step    = (state == ST_RUN);
    strobe.capture = (state == ST_FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= (state == ST_FINISH);
      unique case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (start) state <= ST_RUN;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LastStep) state <= ST_FINISH;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign doneOut = doneReg;

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);

  mulStrobe_t strobe;

  booth_control #(.WIDTH(WIDTH)) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .doneOut(done)
  );

  booth_datapath #(.WIDTH(WIDTH)) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mcandIn  (multiplicand),
    .mplierIn (multiplier),
    .resultOut(product)
  );

endmodule

// File: rtl/booth_seq_mul_checker.sv
module booth_seq_mul_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic [2*WIDTH-1:0] product,
  input logic               done
);

  localparam int CntW = $clog2(WIDTH + 3) + 1;

  logic                     inFlight;
  logic [CntW-1:0]          edgeCnt;
  logic signed [WIDTH-1:0]  opA;
  logic signed [WIDTH-1:0]  opB;
  logic signed [2*WIDTH-1:0] expProd;

  assign expProd = opA * opB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      edgeCnt  <= '0;
      opA      <= '0;
      opB      <= '0;
    end else if (start && (!inFlight || done)) begin
      inFlight <= 1'b1;
      edgeCnt  <= '0;
      opA      <= multiplicand;
      opB      <= multiplier;
    end else if (inFlight) begin
      if (done) inFlight <= 1'b0;
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (!done && product == '0);
    end
  end

  // R5, R6: done arrives exactly WIDTH+1 edges after acceptance
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (inFlight && edgeCnt == CntW'(WIDTH + 1)));

  // R5: single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  a_r7_product_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(product) |-> done);

  // R8, R4, R3
  a_r8_signed_product: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == expProd));

endmodule

bind booth_seq_mul booth_seq_mul_checker #(.WIDTH(WIDTH)) chk (.*);

// File: tb/booth_seq_mul_test.sv
`timescale 1ns/1ps
module booth_seq_mul_test;

  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   multiplicand = '0;
  logic [W-1:0]   multiplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int testsRun = 0;
  int testsFailed = 0;

  booth_seq_mul #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .done(done)
  );

  always #5 clk = ~clk;

  function automatic logic [2*W-1:0] refMul(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [2*W-1:0] sa;
    logic signed [2*W-1:0] sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // injectAt >= 0 pulses start with other operands that many cycles into the run (R6)
  task automatic runMul(logic [W-1:0] a, logic [W-1:0] b, string req, int injectAt);
    int lat;
    logic [2*W-1:0] held;
    @(negedge clk);
    multiplicand = a;
    multiplier   = b;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 60) begin
      if (lat == injectAt) begin
        start = 1'b1;
        multiplicand = ~a;
        multiplier   = b ^ 8'h5A;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check({req, " R5 latency"}, 2*W'(lat), 2*W'(W + 1));
    check(req, product, refMul(a, b));
    held = product;
    multiplicand = ~a;
    multiplier   = ~b;
    @(negedge clk);
    check("R5 done pulse width", {15'd0, done}, '0);
    repeat (3) @(negedge clk);
    check("R7 product held", product, held);
  endtask

  initial begin
    #2_000_000;
    testsFailed++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    repeat (2) @(negedge clk);
    check("R1 reset product", product, '0);
    check("R1 reset done", {15'd0, done}, '0);
    rstN = 1'b1;
    @(negedge clk);

    runMul(8'd2, 8'd7, "R8 2x7", -1);
    runMul(8'd2, 8'hFD, "R8 2x-3", -1);
    runMul(8'd37, 8'hFF, "R2 multiplier all ones", -1);
    runMul(8'hC3, 8'd1, "R2 multiplier one", -1);
    runMul(8'd19, 8'h55, "R2 alternating bits", -1);
    runMul(8'd23, 8'h3C, "R2 middle run of ones", -1);
    runMul(8'hE5, 8'h6B, "R3 negative multiplicand", -1);
    runMul(8'd91, 8'h94, "R3 negative multiplier", -1);
    runMul(8'h80, 8'h80, "R4 most negative squared", -1);
    runMul(8'h80, 8'h7F, "R4 most negative times max", -1);
    runMul(8'h80, 8'hFF, "R4 most negative times -1", -1);
    runMul(8'h7F, 8'h7F, "R8 max squared", -1);
    runMul(8'd0, 8'hA7, "R8 zero multiplicand", -1);
    runMul(8'd45, 8'h92, "R6 start ignored while busy", 3);
    runMul(8'hB1, 8'h2E, "R6 start ignored late in run", W - 1);

    for (int i = 0; i < 120; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = W'($urandom);
      rb = W'($urandom);
      runMul(ra, rb, "R8 random", -1);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule